// File: doc/BRIEF.md
# Jumper-Configurable Bus Block Decoder

This block is an address decoder for an expansion card on an 8-bit bus of the Z80 kind. It compares the low eight address lines with a programmed start address. A per-line compare mask chooses which lines take part, and the lowest compared line sets the block size. The match is then qualified by the selected request strobe, which is either the I/O request or the memory request. Optionally the opcode-fetch strobe also qualifies it, so that interrupt-acknowledge cycles are kept out.

Inside a selected block, eight active-low sub-select lines split the block into groups of 1, 2, 4 or 8 addresses. The block also drives the enable and direction pins of an external bidirectional data transceiver.

The configuration pins model jumper fields and are held static. No data stream passes through the block, so it has no valid/ready handshake. Every pin is plain level logic, and the decode is purely combinational.

Top module: `ioblk_decoder`

## Requirements
- R1: An address line takes part in the compare only when its bit in `cfg_cmp_mask` is 1. Lines with a 0 mask bit have no effect on the match, so the lowest set mask bit fixes the block size: mask F0h gives 16 addresses, F8h gives 8 and E0h gives 32.
- R2: A 1 in `cfg_start_inv[i]` requires address line i to be low, and a 0 requires it to be high. With mask F0h, the value 30h selects the block C0h-CFh.
- R3: `cfg_use_mreq` = 0 makes `iorq_n` the qualifying strobe, and 1 makes `mreq_n` the qualifying strobe. The other strobe has no effect.
- R4: When `cfg_gate_m1` = 1, a low `m1_n` keeps `blk_sel_n` high. When `cfg_gate_m1` = 0, `m1_n` is ignored.
- R5: `blk_sel_n` is low exactly when the masked compare matches and the qualifying strobe is low, subject to R4.
- R6: `cfg_grp` = k (0..3) gives groups of 2^k addresses. `sub_sel_n[j]` is low exactly when `blk_sel_n` is low and (A[3:0] >> k) equals j. With k = 0 and A3 = 1, no line is low. At most one line is low at any time.
- R7: When `cfg_xcvr_always` = 1, `xcvr_en_n` is held low. When it is 0, `xcvr_en_n` equals `blk_sel_n`.
- R8: `xcvr_dir_n` is low (data toward the CPU) exactly when `rd_n` is low, `blk_sel_n` is low and `cfg_write_only` is 0. Otherwise it is high (data toward the card).
- R9: All outputs settle in the same cycle as the inputs change, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 8 | Low address lines A7..A0 |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cfg_cmp_mask | input | 8 | 1 = address line is compared |
| cfg_start_inv | input | 8 | 1 = line must be low, 0 = line must be high |
| cfg_use_mreq | input | 1 | Qualifier select: 0 I/O request, 1 memory request |
| cfg_gate_m1 | input | 1 | 1 = low m1_n blocks selection |
| cfg_grp | input | 2 | Sub-select group size, 2^cfg_grp addresses |
| cfg_xcvr_always | input | 1 | 1 = transceiver enabled at all times |
| cfg_write_only | input | 1 | 1 = direction held toward the card |
| blk_sel_n | output | 1 | Qualified block select, active low |
| sub_sel_n | output | 8 | Grouped sub-selects, active low |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir_n | output | 1 | Transceiver direction, low = toward CPU |

## Verification
Three things resolve together for the same address: the block match and the sub-select group, and an interrupt-acknowledge (low `m1_n`) can coincide with a matching I/O request. The bench sweeps every address under six configurations and four strobe patterns. One of those patterns asserts `iorq_n` and `m1_n` together. For each case the bench computes the block base from the mask, the group index by shifting, and the transceiver pins from the strobes. It then compares all outputs against these values after a short settling delay, so a sub-select that leaks during a gated acknowledge cycle shows up as a mismatch.

// File: rtl/ioblk_pkg.sv
package ioblk_pkg;
  localparam int unsigned BUS_AW    = 8;
  localparam int unsigned SUB_AW    = 4;
  localparam int unsigned SUB_LINES = 8;
  localparam int unsigned GRP_W     = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_1 = 2'd0,
    GRP_2 = 2'd1,
    GRP_4 = 2'd2,
    GRP_8 = 2'd3
  } grp_e;
endpackage

// File: rtl/ioblk_match.sv
module ioblk_match #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] start_inv,
  output logic          hit
);
  logic [AW-1:0] bit_ok;

  // One slice per line: an unmasked line always passes. A masked line
  // passes when it differs from its inverted start bit.
  for (genvar i = 0; i < AW; i++) begin : g_slice
    assign bit_ok[i] = ~mask[i] | (addr[i] ^ start_inv[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/ioblk_qual.sv
module ioblk_qual (
  input  logic hit,
  input  logic iorq_n,
  input  logic mreq_n,
  input  logic m1_n,
  input  logic use_mreq,
  input  logic gate_m1,
  output logic sel
);
  logic strobe;
  logic m1_ok;

  always_comb begin
    strobe = use_mreq ? ~mreq_n : ~iorq_n;
    m1_ok  = ~(gate_m1 & ~m1_n);
    sel    = hit & strobe & m1_ok;
  end
endmodule

// File: rtl/ioblk_subdec.sv
module ioblk_subdec #(
  parameter int unsigned SUB_AW    = 4,
  parameter int unsigned SUB_LINES = 8,
  parameter int unsigned GRP_W     = 2
) (
  input  logic [SUB_AW-1:0]    low_addr,
  input  logic [GRP_W-1:0]     grp,
  input  logic                 sel,
  output logic [SUB_LINES-1:0] sub_n
);
  logic [SUB_AW-1:0] idx;

  assign idx = low_addr >> grp;

  for (genvar j = 0; j < SUB_LINES; j++) begin : g_line
    assign sub_n[j] = ~(sel && (idx == SUB_AW'(j)));
  end
endmodule

// File: rtl/ioblk_xcvr.sv
module ioblk_xcvr (
  input  logic sel,
  input  logic rd_n,
  input  logic always_on,
  input  logic write_only,
  output logic en_n,
  output logic dir_n
);
  always_comb begin
    en_n  = ~(always_on | sel);
    dir_n = ~(sel & ~rd_n & ~write_only);
  end
endmodule

// File: rtl/ioblk_decoder.sv
module ioblk_decoder
  import ioblk_pkg::*;
(
  input  logic [BUS_AW-1:0]    addr,
  input  logic                 iorq_n,
  input  logic                 mreq_n,
  input  logic                 m1_n,
  input  logic                 rd_n,
  input  logic [BUS_AW-1:0]    cfg_cmp_mask,
  input  logic [BUS_AW-1:0]    cfg_start_inv,
  input  logic                 cfg_use_mreq,
  input  logic                 cfg_gate_m1,
  input  logic [GRP_W-1:0]     cfg_grp,
  input  logic                 cfg_xcvr_always,
  input  logic                 cfg_write_only,
  output logic                 blk_sel_n,
  output logic [SUB_LINES-1:0] sub_sel_n,
  output logic                 xcvr_en_n,
  output logic                 xcvr_dir_n
);
  logic hit;
  logic sel;

  ioblk_match #(.AW(BUS_AW)) u_match (
    .addr      (addr),
    .mask      (cfg_cmp_mask),
    .start_inv (cfg_start_inv),
    .hit       (hit)
  );

  ioblk_qual u_qual (
    .hit      (hit),
    .iorq_n   (iorq_n),
    .mreq_n   (mreq_n),
    .m1_n     (m1_n),
    .use_mreq (cfg_use_mreq),
    .gate_m1  (cfg_gate_m1),
    .sel      (sel)
  );

  ioblk_subdec #(
    .SUB_AW    (SUB_AW),
    .SUB_LINES (SUB_LINES),
    .GRP_W     (GRP_W)
  ) u_subdec (
    .low_addr (addr[SUB_AW-1:0]),
    .grp      (cfg_grp),
    .sel      (sel),
    .sub_n    (sub_sel_n)
  );

  ioblk_xcvr u_xcvr (
    .sel        (sel),
    .rd_n       (rd_n),
    .always_on  (cfg_xcvr_always),
    .write_only (cfg_write_only),
    .en_n       (xcvr_en_n),
    .dir_n      (xcvr_dir_n)
  );

  assign blk_sel_n = ~sel;
endmodule

// File: rtl/ioblk_decoder_chk.sv
module ioblk_decoder_chk
  import ioblk_pkg::*;
(
  input logic [BUS_AW-1:0]    addr,
  input logic                 iorq_n,
  input logic                 mreq_n,
  input logic                 m1_n,
  input logic                 rd_n,
  input logic [BUS_AW-1:0]    cfg_cmp_mask,
  input logic [BUS_AW-1:0]    cfg_start_inv,
  input logic                 cfg_use_mreq,
  input logic                 cfg_gate_m1,
  input logic [GRP_W-1:0]     cfg_grp,
  input logic                 cfg_xcvr_always,
  input logic                 cfg_write_only,
  input logic                 blk_sel_n,
  input logic [SUB_LINES-1:0] sub_sel_n,
  input logic                 xcvr_en_n,
  input logic                 xcvr_dir_n
);
  always_comb begin
    assert_sub_onehot_R6: assert ($onehot0(~sub_sel_n))
      else $error("more than one sub-select low");
    if (sub_sel_n != '1)
      assert_sub_needs_blk_R6: assert (!blk_sel_n)
        else $error("sub-select low without block select");
    if (!blk_sel_n)
      assert_strobe_R3: assert (cfg_use_mreq ? !mreq_n : !iorq_n)
        else $error("block select without qualifying strobe");
    if (cfg_gate_m1 && !m1_n)
      assert_m1_gate_R4: assert (blk_sel_n)
        else $error("block selected during gated m1 cycle");
    if (!blk_sel_n)
      assert_addr_match_R1: assert ((addr & cfg_cmp_mask) == (~cfg_start_inv & cfg_cmp_mask))
        else $error("block selected on mismatching address");
    if (!cfg_xcvr_always)
      assert_en_follows_R7: assert (xcvr_en_n == blk_sel_n)
        else $error("transceiver enable disagrees with block select");
    if (!xcvr_dir_n)
      assert_dir_needs_en_R8: assert (!xcvr_en_n && !rd_n)
        else $error("direction toward CPU without enable or read");
  end
endmodule

bind ioblk_decoder ioblk_decoder_chk u_chk (.*);

// File: tb/ioblk_decoder_bench.sv
module ioblk_decoder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] addr = 8'h00;
  logic iorq_n = 1'b1, mreq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1;
  logic [7:0] cfg_cmp_mask = 8'hF0, cfg_start_inv = 8'h30;
  logic cfg_use_mreq = 1'b0, cfg_gate_m1 = 1'b0;
  logic [1:0] cfg_grp = 2'd2;
  logic cfg_xcvr_always = 1'b0, cfg_write_only = 1'b0;
  logic blk_sel_n, xcvr_en_n, xcvr_dir_n;
  logic [7:0] sub_sel_n;
  logic rst_n = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ioblk_decoder u_ioblk_decoder (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (addr %02h)", req, act, exp, addr);
    end
  endtask

  // Selection from requirements: base is the value the compared lines must hold.
  function automatic bit exp_sel(logic [7:0] a);
    logic [7:0] base;
    bit strobe;
    base   = ~cfg_start_inv & cfg_cmp_mask;
    strobe = cfg_use_mreq ? !mreq_n : !iorq_n;
    if (cfg_gate_m1 && !m1_n) strobe = 1'b0;
    return strobe && ((a & cfg_cmp_mask) == base);
  endfunction

  task automatic drive_pat(int p);
    case (p)
      0: begin iorq_n = 0; mreq_n = 1; m1_n = 1; rd_n = 0; end
      1: begin iorq_n = 1; mreq_n = 0; m1_n = 1; rd_n = 1; end
      2: begin iorq_n = 0; mreq_n = 1; m1_n = 0; rd_n = 0; end
      default: begin iorq_n = 1; mreq_n = 1; m1_n = 1; rd_n = 0; end
    endcase
  endtask

  task automatic apply(logic [7:0] a, int p);
    bit s;
    int idx;
    logic [7:0] sub_exp;
    @(negedge clk);
    addr = a;
    drive_pat(p);
    #2;
    s   = exp_sel(a);
    idx = int'(a[3:0]) / (1 << cfg_grp);
    sub_exp = (s && idx < 8) ? ~(8'h01 << idx) : 8'hFF;
    chk("R5 blk_sel_n", {7'd0, blk_sel_n}, {7'd0, !s});
    chk("R6 sub_sel_n", sub_sel_n, sub_exp);
    chk("R7 xcvr_en_n", {7'd0, xcvr_en_n}, {7'd0, !(cfg_xcvr_always || s)});
    chk("R8 xcvr_dir_n", {7'd0, xcvr_dir_n}, {7'd0, !(s && !rd_n && !cfg_write_only)});
  endtask

  task automatic set_cfg(logic [7:0] m, logic [7:0] si, bit mr, bit g1,
                         logic [1:0] gp, bit alw, bit wo);
    cfg_cmp_mask = m; cfg_start_inv = si; cfg_use_mreq = mr; cfg_gate_m1 = g1;
    cfg_grp = gp; cfg_xcvr_always = alw; cfg_write_only = wo;
  endtask

  task automatic sweep();
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 256; a++) apply(8'(a), p);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all strobes idle
    chk("R5 reset blk", {7'd0, blk_sel_n}, 8'h01);
    chk("R6 reset sub", sub_sel_n, 8'hFF);
    chk("R7 reset en", {7'd0, xcvr_en_n}, 8'h01);
    chk("R8 reset dir", {7'd0, xcvr_dir_n}, 8'h01);
    rst_n = 1'b1;

    // 16-address block at C0h, groups of four
    set_cfg(8'hF0, 8'h30, 0, 0, 2'd2, 0, 0);
    apply(8'hC5, 0); chk("R2 C5h selected", {7'd0, blk_sel_n}, 8'h00);
    chk("R6 C5h group1", sub_sel_n, 8'hFD);
    apply(8'hCF, 0); chk("R1 CFh low lines ignored", sub_sel_n, 8'hF7);
    apply(8'hD0, 0); chk("R1 D0h outside", {7'd0, blk_sel_n}, 8'h01);
    apply(8'hC0, 1); chk("R3 mreq ignored in io mode", {7'd0, blk_sel_n}, 8'h01);
    apply(8'hC0, 2); chk("R4 m1 ignored when not gated", {7'd0, blk_sel_n}, 8'h00);
    // R9: address change without a clock edge
    #1 addr = 8'h40; #1;
    chk("R9 same-cycle deselect", {7'd0, blk_sel_n}, 8'h01);
    sweep();

    set_cfg(8'hF8, 8'h38, 0, 0, 2'd0, 0, 0); sweep();   // R1 8-address block
    set_cfg(8'hE0, 8'h20, 1, 1, 2'd3, 0, 0); sweep();   // R3 mreq, R4 m1 gating
    apply(8'hC0, 1); chk("R3 mreq qualifies", {7'd0, blk_sel_n}, 8'h00);
    set_cfg(8'hE0, 8'h20, 0, 1, 2'd3, 0, 0);
    apply(8'hC1, 2); chk("R4 gated ack blocked", {7'd0, blk_sel_n}, 8'h01);
    chk("R4 gated ack no sub", sub_sel_n, 8'hFF);
    set_cfg(8'hFF, 8'h00, 0, 0, 2'd1, 1, 1); sweep();   // R7 always, R8 write-only
    set_cfg(8'h00, 8'h00, 0, 1, 2'd1, 0, 0); sweep();   // R1 nothing compared
    set_cfg(8'hF0, 8'hF0, 1, 0, 2'd3, 1, 0); sweep();   // R2 block at 00h

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule